// File: doc/BRIEF.md
# Converter Register Front-End with Completion-Flag Clearing

This block connects a processor bus to a sampled-data converter core. It holds a primary control byte and a companion control byte. It also holds one conversion-complete flag for each channel, a sequence-complete flag and a result store with one entry for each channel. The converter core reports each finished channel with a one-cycle strobe that carries the channel number, the data and a last-of-sequence marker. The block grants the core a clock enable and a run permission, and it sends the core an abort pulse.

Software clears the per-channel flags in one of two ways, selected by a fast-clear control bit. In the normal way, software reads the status byte and then reads that channel's result. In the fast way, any access to the channel's result clears its flag. Every write to either control byte aborts the running sequence. After power-enable goes from 0 to 1, a recovery count must expire before the core may run. While the wait-stop bit is 1, an asserted system wait input halts the core.

Top module: `adc_regif`

## Requirements
- R1: While `rst` is high, and after it, every control bit, channel flag and the sequence flag is 0. `irq`, `core_abort`, `core_clk_en`, `core_run` and `bus_rdata` are 0.
- R2: Address map: 0 is the primary control byte, 1 is the companion byte (all 8 bits read/write), 2 is status (bit c is channel c's flag), and 8+c is result c. Read data appears in the cycle after the request. The primary byte reads as {power-enable[7], fast-clear[6], wait-stop[5], 0[4:2], irq-enable[1], sequence flag[0]}. Bits [4:2] always read 0, and writes to them are dropped.
- R3: A bus write cannot set the sequence flag at bit 0.
- R4: A write to address 0 or 1 produces a `core_abort` pulse one cycle later.
- R5: While power-enable is 0, `core_clk_en` and `core_run` are 0 and incoming completions are discarded.
- R6: With fast-clear 0, a result read clears the channel flag only if a status read came first. A result read with no status read before it leaves the flag set.
- R7: A completion on a channel that arrives between the status read and the result read stays pending. The result read does not clear the flag it set.
- R8: With fast-clear 1, any read or write of result c clears flag c when it is set. Accessing result c while flag c is clear has no effect.
- R9: With wait-stop 1 and `sys_wait` high, `core_run` and `core_clk_en` drop one cycle later. With wait-stop 0, `sys_wait` has no effect.
- R10: Power-enable is sampled set at edge E0. `core_run` becomes 1 at edge E0+REC_CYCLES+1 and not before.
- R11: An abort clears the sequence flag. Channel flags and stored results stay unchanged, and a completion strobe in the aborting cycle is dropped.
- R12: The sequence flag sets on an accepted completion that is marked last, and clears on `core_seq_start`. `irq` is the flag AND irq-enable.
- R13: A completion stores its data for the channel, sets that channel's flag, and a result read returns that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| sys_wait | input | 1 | System wait state |
| core_done_valid | input | 1 | Channel conversion finished |
| core_done_ch | input | CH_W | Finished channel |
| core_done_data | input | RES_W | Conversion result |
| core_done_last | input | 1 | Final channel of the sequence |
| core_seq_start | input | 1 | Core begins a new sequence |
| core_abort | output | 1 | Abort pulse to the sequencer |
| core_clk_en | output | 1 | Converter clock enable |
| core_run | output | 1 | Sequencer may run |
| irq | output | 1 | Sequence-complete interrupt request |

## Verification
The assertions assume that the bus makes at most one access per cycle and that completion strobes are single-cycle pulses that carry a valid channel number. The bench drives requests and strobes at the falling edge as separate pulses, and it keeps the address inside the decoded map. It never reads a result entry before a completion has written it, and it never reads a result in the same cycle that its channel completes.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int unsigned BUS_W = 8;

  typedef struct packed {
    logic pwr;
    logic ffc;
    logic wstop;
    logic ie;
  } ctl_t;

  function automatic logic [BUS_W-1:0] ctl_pack(input ctl_t c, input logic flag);
    return {c.pwr, c.ffc, c.wstop, 3'b000, c.ie, flag};
  endfunction

  function automatic ctl_t ctl_unpack(input logic [BUS_W-1:0] d);
    ctl_t c;
    c.pwr   = d[7];
    c.ffc   = d[6];
    c.wstop = d[5];
    c.ie    = d[1];
    return c;
  endfunction
endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic             wr_ctl2,
  input  logic [BUS_W-1:0] wdata,
  input  logic             last_acc,
  input  logic             seq_start,
  output ctl_t             ctl_q,
  output logic [BUS_W-1:0] ctl2_q,
  output logic             seq_flag,
  output logic             abort_q,
  output logic             irq
);
  logic abort_now;
  assign abort_now = wr_ctl | wr_ctl2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      ctl2_q   <= '0;
      seq_flag <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q  <= ctl_unpack(wdata);
      if (wr_ctl2) ctl2_q <= wdata;
      abort_q <= abort_now;
      if (abort_now)      seq_flag <= 1'b0;
      else if (seq_start) seq_flag <= 1'b0;
      else if (last_acc)  seq_flag <= 1'b1;
    end
  end

  assign irq = seq_flag & ctl_q.ie;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int unsigned REC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr,
  input  logic wstop,
  input  logic sys_wait,
  output logic clk_en,
  output logic run
);
  localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rec_done;
  logic             halt;

  assign halt = wstop & sys_wait;

  always_ff @(posedge clk) begin
    if (rst || !pwr) begin
      cnt_q    <= '0;
      rec_done <= 1'b0;
    end else if (!rec_done) begin
      if (cnt_q == CNT_LAST) rec_done <= 1'b1;
      else                   cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en <= 1'b0;
      run    <= 1'b0;
    end else begin
      clk_en <= pwr & ~halt;
      run    <= pwr & rec_done & ~halt;
    end
  end
endmodule

// File: rtl/adc_ccf_track.sv
module adc_ccf_track #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ffc,
  input  logic            acc_done,
  input  logic [CH_W-1:0] done_ch,
  input  logic            stat_rd,
  input  logic            res_acc,
  input  logic            res_we,
  input  logic [CH_W-1:0] res_ch,
  output logic [N_CH-1:0] ccf
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit_done, hit_res, flag_q, arm_q, clr;
    assign hit_done = acc_done && (done_ch == CH_W'(c));
    assign hit_res  = res_acc && (res_ch == CH_W'(c));
    assign clr      = hit_res && (ffc ? flag_q : (!res_we && arm_q));

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else begin
        if (hit_done) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;

        if (hit_done)                arm_q <= 1'b0;
        else if (stat_rd)            arm_q <= flag_q;
        else if (hit_res && !res_we) arm_q <= 1'b0;
      end
    end
    assign ccf[c] = flag_q;
  end
endmodule

// File: rtl/adc_result_mem.sv
module adc_result_mem #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3,
  parameter int unsigned RES_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CH_W-1:0]  wch,
  input  logic [RES_W-1:0] wdata,
  input  logic             re,
  input  logic [CH_W-1:0]  rch,
  output logic [RES_W-1:0] q
);
  logic [RES_W-1:0] mem [N_CH];

  always_ff @(posedge clk) begin
    if (we) mem[wch] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[rch];
  end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int unsigned N_CH       = 8,
  parameter int unsigned RES_W      = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned ADDR_CTL   = 0,
  parameter int unsigned ADDR_CTL2  = 1,
  parameter int unsigned ADDR_STAT  = 2,
  parameter int unsigned RES_BASE   = 8,
  parameter int unsigned REC_CYCLES = 16,
  localparam int unsigned CH_W      = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sys_wait,
  input  logic              core_done_valid,
  input  logic [CH_W-1:0]   core_done_ch,
  input  logic [RES_W-1:0]  core_done_data,
  input  logic              core_done_last,
  input  logic              core_seq_start,
  output logic              core_abort,
  output logic              core_clk_en,
  output logic              core_run,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(ADDR_CTL2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(RES_BASE);

  logic              wr, rd, wr_ctl, wr_ctl2, stat_rd, is_res, acc_done;
  logic [ADDR_W-1:0] res_off;
  logic [CH_W-1:0]   res_ch;
  ctl_t              ctl_q;
  logic [7:0]        ctl2_q;
  logic              seq_flag;
  logic [N_CH-1:0]   ccf;
  logic [RES_W-1:0]  mem_q;
  logic [7:0]        rd_q;
  logic              sel_res_q;
  logic              ctl_pwr, ctl_ws;

  assign wr       = bus_req & bus_we;
  assign rd       = bus_req & ~bus_we;
  assign wr_ctl   = wr && (bus_addr == A_CTL);
  assign wr_ctl2  = wr && (bus_addr == A_CTL2);
  assign stat_rd  = rd && (bus_addr == A_STAT);
  assign res_off  = bus_addr - A_RES;
  assign is_res   = (bus_addr >= A_RES) && (32'(res_off) < N_CH);
  assign res_ch   = res_off[CH_W-1:0];
  assign acc_done = core_done_valid & ctl_q.pwr & ~(wr_ctl | wr_ctl2);
  assign ctl_pwr  = ctl_q.pwr;
  assign ctl_ws   = ctl_q.wstop;

  adc_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wr_ctl2   (wr_ctl2),
    .wdata     (bus_wdata),
    .last_acc  (acc_done & core_done_last),
    .seq_start (core_seq_start),
    .ctl_q     (ctl_q),
    .ctl2_q    (ctl2_q),
    .seq_flag  (seq_flag),
    .abort_q   (core_abort),
    .irq       (irq)
  );

  adc_pwr_seq #(.REC_CYCLES(REC_CYCLES)) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .pwr      (ctl_q.pwr),
    .wstop    (ctl_q.wstop),
    .sys_wait (sys_wait),
    .clk_en   (core_clk_en),
    .run      (core_run)
  );

  adc_ccf_track #(.N_CH(N_CH), .CH_W(CH_W)) u_ccf (
    .clk      (clk),
    .rst      (rst),
    .ffc      (ctl_q.ffc),
    .acc_done (acc_done),
    .done_ch  (core_done_ch),
    .stat_rd  (stat_rd),
    .res_acc  (bus_req & is_res),
    .res_we   (bus_we),
    .res_ch   (res_ch),
    .ccf      (ccf)
  );

  adc_result_mem #(.N_CH(N_CH), .CH_W(CH_W), .RES_W(RES_W)) u_mem (
    .clk   (clk),
    .we    (acc_done),
    .wch   (core_done_ch),
    .wdata (core_done_data),
    .re    (rd & is_res),
    .rch   (res_ch),
    .q     (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      sel_res_q <= 1'b0;
    end else if (rd) begin
      sel_res_q <= is_res;
      rd_q      <= '0;
      if (bus_addr == A_CTL)       rd_q <= ctl_pack(ctl_q, seq_flag);
      else if (bus_addr == A_CTL2) rd_q <= ctl2_q;
      else if (bus_addr == A_STAT) rd_q[N_CH-1:0] <= ccf;
    end
  end

  assign bus_rdata = sel_res_q ? 8'(mem_q) : rd_q;
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned ADDR_CTL  = 0,
  parameter int unsigned ADDR_CTL2 = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              sys_wait,
  input logic              core_done_valid,
  input logic              core_done_last,
  input logic              core_abort,
  input logic              core_run,
  input logic              ctl_pwr,
  input logic              ctl_ws,
  input logic              seq_flag,
  input logic [N_CH-1:0]   ccf
);
  logic ctl_write, ctl_read;
  assign ctl_write = bus_req && bus_we &&
                     (bus_addr == ADDR_W'(ADDR_CTL) || bus_addr == ADDR_W'(ADDR_CTL2));
  assign ctl_read  = bus_req && !bus_we && (bus_addr == ADDR_W'(ADDR_CTL));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl_read |=> (bus_rdata[4:2] == 3'b000)); // R2
  AST_FLAG_RO: assert property (@(posedge clk) disable iff (rst)
    ctl_write |=> !seq_flag); // R3
  AST_ABORT_ON_WR: assert property (@(posedge clk) disable iff (rst)
    ctl_write |=> core_abort); // R4
  AST_OFF_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    !ctl_pwr |=> !core_run); // R5
  AST_CCF_FALL_BUS: assert property (@(posedge clk) disable iff (rst)
    (|($past(ccf) & ~ccf)) |-> $past(bus_req)); // R6
  AST_WAIT_HALT: assert property (@(posedge clk) disable iff (rst)
    (ctl_ws && sys_wait) |=> !core_run); // R9
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (rst)
    core_abort |-> ($stable(ccf) && !seq_flag)); // R11
  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_flag) |-> $past(core_done_valid && core_done_last)); // R12
endmodule

bind adc_regif adc_regif_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .ADDR_CTL(ADDR_CTL), .ADDR_CTL2(ADDR_CTL2)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_req         (bus_req),
  .bus_we          (bus_we),
  .bus_addr        (bus_addr),
  .bus_rdata       (bus_rdata),
  .sys_wait        (sys_wait),
  .core_done_valid (core_done_valid),
  .core_done_last  (core_done_last),
  .core_abort      (core_abort),
  .core_run        (core_run),
  .ctl_pwr         (ctl_pwr),
  .ctl_ws          (ctl_ws),
  .seq_flag        (seq_flag),
  .ccf             (ccf)
);

// File: tb/tb_adc_regif.sv
`timescale 1ns/1ps
module tb_adc_regif;
  localparam int TB_REC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_req = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sys_wait = 0;
  logic       core_done_valid = 0, core_done_last = 0, core_seq_start = 0;
  logic [2:0] core_done_ch = '0;
  logic [7:0] core_done_data = '0;
  logic       core_abort, core_clk_en, core_run, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  adc_regif #(.REC_CYCLES(TB_REC)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_wait(sys_wait), .core_done_valid(core_done_valid),
    .core_done_ch(core_done_ch), .core_done_data(core_done_data),
    .core_done_last(core_done_last), .core_seq_start(core_seq_start),
    .core_abort(core_abort), .core_clk_en(core_clk_en),
    .core_run(core_run), .irq(irq)
  );

  // Reference model state
  bit m_pwr, m_ffc, m_ws, m_ie, m_flag, m_abort, m_clk_en, m_run, m_rdone;
  bit [7:0] m_ctl2, m_rdata, m_ccf, m_arm;
  bit [7:0] m_res [8];
  int m_cnt;
  bit wc, wc2, rdx, isr, ad;
  int rch;
  bit [7:0] n_ccf, n_arm, n_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_pwr = 0; m_ffc = 0; m_ws = 0; m_ie = 0; m_flag = 0; m_abort = 0;
      m_clk_en = 0; m_run = 0; m_rdone = 0; m_ctl2 = 0; m_rdata = 0;
      m_ccf = 0; m_arm = 0; m_cnt = 0;
    end else begin
      wc  = bus_req && bus_we && bus_addr == 0;
      wc2 = bus_req && bus_we && bus_addr == 1;
      rdx = bus_req && !bus_we;
      isr = bus_addr >= 8;
      rch = int'(bus_addr) - 8;
      ad  = core_done_valid && m_pwr && !(wc || wc2);
      n_rdata = m_rdata;
      if (rdx) begin
        if (bus_addr == 0)      n_rdata = {m_pwr, m_ffc, m_ws, 3'b000, m_ie, m_flag};
        else if (bus_addr == 1) n_rdata = m_ctl2;
        else if (bus_addr == 2) n_rdata = m_ccf;
        else if (isr)           n_rdata = m_res[rch];
        else                    n_rdata = 0;
      end
      n_ccf = m_ccf; n_arm = m_arm;
      for (int c = 0; c < 8; c++) begin
        bit hd, hr;
        hd = ad && core_done_ch == 3'(c);
        hr = bus_req && isr && rch == c;
        if (hd) n_ccf[c] = 1;
        else if (hr && (m_ffc ? m_ccf[c] : (!bus_we && m_arm[c]))) n_ccf[c] = 0;
        if (hd) n_arm[c] = 0;
        else if (rdx && bus_addr == 2) n_arm[c] = m_ccf[c];
        else if (hr && !bus_we) n_arm[c] = 0;
      end
      if (ad) m_res[core_done_ch] = core_done_data;
      if (wc || wc2)              m_flag = 0;
      else if (core_seq_start)    m_flag = 0;
      else if (ad && core_done_last) m_flag = 1;
      m_clk_en = m_pwr && !(m_ws && sys_wait);
      m_run    = m_pwr && m_rdone && !(m_ws && sys_wait);
      if (!m_pwr) begin m_cnt = 0; m_rdone = 0; end
      else if (!m_rdone) begin
        if (m_cnt == TB_REC - 1) m_rdone = 1; else m_cnt++;
      end
      m_abort = wc || wc2;
      if (wc) begin
        m_pwr = bus_wdata[7]; m_ffc = bus_wdata[6]; m_ws = bus_wdata[5]; m_ie = bus_wdata[1];
      end
      if (wc2) m_ctl2 = bus_wdata;
      m_ccf = n_ccf; m_arm = n_arm; m_rdata = n_rdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R13 rdata", bus_rdata, m_rdata);
      chk("R4 abort", core_abort, m_abort);
      chk("R5 clk_en", core_clk_en, m_clk_en);
      chk("R10 run", core_run, m_run);
      chk("R12 irq", irq, m_flag & m_ie);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0; d = bus_rdata;
  endtask

  task automatic conv(input logic [2:0] ch, input logic [7:0] d, input logic last);
    @(negedge clk); core_done_valid = 1; core_done_ch = ch; core_done_data = d; core_done_last = last;
    @(negedge clk); core_done_valid = 0; core_done_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 abort", core_abort, 0);
    chk("R1 run", core_run, 0); chk("R1 rdata", bus_rdata, 0);
    rst = 0;
    rd(0, v); chk("R1 ctl", v, 8'h00);
    rd(2, v); chk("R1 status", v, 8'h00);

    wr(0, 8'hFF); chk("R4 abort pulse", core_abort, 1);
    idle(1);      chk("R4 abort single", core_abort, 0);
    rd(0, v);     chk("R2 R3 ctl readback", v, 8'hE2);
    wr(1, 8'hA5); rd(1, v); chk("R2 companion", v, 8'hA5);

    wr(0, 8'h00); idle(2);
    chk("R5 clk_en off", core_clk_en, 0);
    conv(0, 8'h11, 1);
    rd(2, v); chk("R5 completion dropped", v, 8'h00);
    rd(0, v); chk("R5 no seq flag", v, 8'h00);

    wr(0, 8'h80);
    idle(TB_REC); chk("R10 run not early", core_run, 0);
    idle(1);      chk("R10 run after recovery", core_run, 1);

    conv(3, 8'h5A, 0);
    rd(2, v); chk("R13 flag set", v, 8'h08);
    rd(11, v); chk("R13 result", v, 8'h5A);
    rd(2, v); chk("R6 cleared by sequence", v, 8'h00);

    conv(1, 8'h21, 0);
    rd(9, v); chk("R13 result ch1", v, 8'h21);
    rd(2, v); chk("R6 no status first", v, 8'h02);
    conv(1, 8'h22, 0);
    rd(9, v); chk("R13 result ch1 new", v, 8'h22);
    rd(2, v); chk("R7 late completion kept", v, 8'h02);
    rd(9, v);
    rd(2, v); chk("R6 cleared after arm", v, 8'h00);

    wr(0, 8'hC0);
    conv(5, 8'h55, 0);
    wr(13, 8'h00);
    rd(2, v); chk("R8 write clears", v, 8'h00);
    conv(6, 8'h66, 0);
    rd(14, v); chk("R8 read data", v, 8'h66);
    rd(2, v); chk("R8 read clears", v, 8'h00);
    conv(7, 8'h77, 0);
    rd(2, v); chk("R8 set again", v, 8'h80);

    wr(0, 8'hC2);
    conv(2, 8'h2C, 1);
    chk("R12 irq set", irq, 1);
    @(negedge clk); core_seq_start = 1; @(negedge clk); core_seq_start = 0;
    chk("R12 irq clear on start", irq, 0);
    conv(4, 8'h4D, 1);
    chk("R12 irq again", irq, 1);
    wr(1, 8'h3C);
    chk("R11 abort clears irq", irq, 0);
    rd(0, v); chk("R11 flag clear", v, 8'hC2);
    rd(2, v); chk("R11 flags kept", v, 8'h94);
    rd(12, v); chk("R11 result kept", v, 8'h4D);

    @(negedge clk); core_done_valid = 1; core_done_ch = 0; core_done_data = 8'h99;
    bus_req = 1; bus_we = 1; bus_addr = 0; bus_wdata = 8'h80;
    @(negedge clk); core_done_valid = 0; bus_req = 0; bus_we = 0;
    rd(2, v); chk("R11 strobe in abort dropped", v, 8'h84);

    wr(0, 8'hA0); sys_wait = 1; idle(2);
    chk("R9 halted run", core_run, 0); chk("R9 halted clk", core_clk_en, 0);
    sys_wait = 0; idle(2); chk("R9 resume", core_run, 1);
    wr(0, 8'h80); sys_wait = 1; idle(2);
    chk("R9 wait ignored", core_run, 1);
    sys_wait = 0; idle(2);
    finish_up();
  end
endmodule